// File: doc/BRIEF.md
# External Memory Access Sequencer with Strobe and Wait-State Control

This block runs one access at a time on a microcontroller-style external memory bus. A request carries a 24-bit address, a direction flag, a two-bit byte select and write data. Static settings choose the bus width (8 or 16 bits), whether address and data share pins (multiplexed mode), how the write strobe is qualified, and whether the ready input may stretch the cycle.

Each accepted request passes through a fixed sequence. First comes a one-cycle address phase, in which the latch-enable pulses in multiplexed mode. Then comes a strobe phase of at least one cycle, which the ready input can prolong. Last is a one-cycle completion phase that releases the strobes, captures read data and pulses `done`. The upper eight address bits drive the segment address lines for the whole access. The lower sixteen bits drive the bus address output.

Top module: `ext_bus_strobe_ctl`

## Requirements
- R1: After reset and with no request, `ale`=0, `rd_n`=1, `wr_n`=1, `done`=0, `busy`=0 and `rdata`=0.
- R2: A request with `req_valid`=1 in an idle cycle is accepted at that clock edge. The next cycle is the address phase, in which `ale` is 1 exactly when `cfg_mux`=1. `ale` is never 1 in any other cycle.
- R3: For an access with `req_write`=0, `rd_n` is 0 in every strobe-phase cycle and 1 elsewhere. `wr_n` stays 1.
- R4: With `cfg_wr_lowbyte`=0, every access with `req_write`=1 drives `wr_n` to 0 in every strobe-phase cycle.
- R5: With `cfg_wr_lowbyte`=1 and `cfg_bus16`=1, `wr_n` goes low only for writes with `req_be[0]`=1 (the low byte). A write that only sets `req_be[1]` runs the full sequence with `wr_n` held at 1.
- R6: With `cfg_wr_lowbyte`=1 and `cfg_bus16`=0, every write drives `wr_n` low in the strobe phase, regardless of `req_be`.
- R7: With `cfg_ready_en`=1, `ready` passes through two flip-flops. The strobe phase ends at the first clock edge after its first cycle at which the synchronized ready is low. If `ready` falls at the input in the same cycle the request is presented, or k cycles later, the strobe is active for k+1 cycles. If `ready` is already low and synchronized, the strobe lasts 1 cycle.
- R8: With `cfg_ready_en`=0, the `ready` input is ignored and the strobe lasts exactly one cycle.
- R9: `rd_n` and `wr_n` are never low in the same cycle, and neither is low while `ale` is high.
- R10: From the address phase through the completion cycle, `seg_addr` equals request address bits 23..16 (bit 16 on `seg_addr[0]`) and `bus_addr` equals bits 15..0.
- R11: `done` is high for exactly one cycle, immediately after the last strobe-phase cycle. For a read, `rdata` then holds the `bus_din` value present at the edge that released `rd_n`. A write leaves `rdata` unchanged.
- R12: `busy` is high from the address phase through the completion cycle. A `req_valid` seen while `busy` is high is ignored and starts no further access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_addr | input | 24 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte select: bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| cfg_bus16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_mux | input | 1 | 1 = multiplexed address/data bus |
| cfg_wr_lowbyte | input | 1 | Write strobe mode: 0 = all writes, 1 = low-byte writes on a 16-bit bus |
| cfg_ready_en | input | 1 | Enables wait-state insertion from `ready` |
| ready | input | 1 | Asynchronous ready, high holds the cycle |
| bus_din | input | 16 | Data returned by external memory |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| seg_addr | output | 8 | Segment address lines (address bits 23..16) |
| bus_addr | output | 16 | Address bits 15..0 |
| bus_dout | output | 16 | Latched write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |

## Verification
The hardest case to reach is a wait state whose length is set by when `ready` falls relative to the two-flop synchronizer. The stimulus first holds `ready` high long enough to settle through both flops. It then drops `ready` a chosen number of cycles after the request and checks the strobe length against that count. The read data bus changes every cycle, so an off-by-one capture edge shows up as a data mismatch. Random runs combine drop times, write-strobe modes, bus widths and requests held during a busy access.

// File: rtl/ext_bus_strobe_ctl.sv
module ext_bus_strobe_ctl #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 8,
  parameter int BE_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_write,
  input  logic [BE_W-1:0]       req_be,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic                  cfg_bus16,
  input  logic                  cfg_mux,
  input  logic                  cfg_wr_lowbyte,
  input  logic                  cfg_ready_en,
  input  logic                  ready,
  input  logic [DATA_W-1:0]     bus_din,
  output logic                  ale,
  output logic                  rd_n,
  output logic                  wr_n,
  output logic [SEG_W-1:0]      seg_addr,
  output logic [ADDR_W-SEG_W-1:0] bus_addr,
  output logic [DATA_W-1:0]     bus_dout,
  output logic                  busy,
  output logic                  done,
  output logic [DATA_W-1:0]     rdata
);
  localparam int LOW_W = ADDR_W - SEG_W;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_STROBE, ST_WAIT, ST_DONE} state_t;

  state_t            state, state_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;
  logic              write_q, bus16_q, mux_q, lowbyte_q, rdyen_q;
  logic              rdy_meta, rdy_sync;
  logic              strobe_on, wr_gate, hold_cycle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_meta <= 1'b0;
      rdy_sync <= 1'b0;
    end else begin
      rdy_meta <= ready;
      rdy_sync <= rdy_meta;
    end
  end

  assign hold_cycle = rdyen_q && rdy_sync;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (req_valid) state_nx = ST_ADDR;
      ST_ADDR:   state_nx = ST_STROBE;
      ST_STROBE: state_nx = hold_cycle ? ST_WAIT : ST_DONE;
      ST_WAIT:   if (!hold_cycle) state_nx = ST_DONE;
      ST_DONE:   state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      write_q   <= 1'b0;
      bus16_q   <= 1'b0;
      mux_q     <= 1'b0;
      lowbyte_q <= 1'b0;
      rdyen_q   <= 1'b0;
      rdata     <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && req_valid) begin
        addr_q    <= req_addr;
        wdata_q   <= req_wdata;
        be_q      <= req_be;
        write_q   <= req_write;
        bus16_q   <= cfg_bus16;
        mux_q     <= cfg_mux;
        lowbyte_q <= cfg_wr_lowbyte;
        rdyen_q   <= cfg_ready_en;
      end
      if (strobe_on && state_nx == ST_DONE && !write_q)
        rdata <= bus_din;
    end
  end

  assign strobe_on = (state == ST_STROBE) || (state == ST_WAIT);
  assign wr_gate   = write_q && (!lowbyte_q || !bus16_q || be_q[0]);
  assign ale       = (state == ST_ADDR) && mux_q;
  assign rd_n      = !(strobe_on && !write_q);
  assign wr_n      = !(strobe_on && wr_gate);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign seg_addr  = addr_q[ADDR_W-1:LOW_W];
  assign bus_addr  = addr_q[LOW_W-1:0];
  assign bus_dout  = wdata_q;

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R9
  AST_NO_STROBE_WITH_ALE: assert property (@(posedge clk) disable iff (!rst_n) ale |-> (rd_n && wr_n)); // R9
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(strobe_on)); // R11
  AST_WAIT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_WAIT) |-> rdyen_q); // R8
  AST_SEG_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(seg_addr)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (rd_n && wr_n && !ale && !done)); // R12
endmodule

// File: tb/sim_ext_bus_strobe_ctl.sv
module sim_ext_bus_strobe_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic req_write = 1'b0;
  logic [1:0] req_be = '0;
  logic [15:0] req_wdata = '0;
  logic cfg_bus16 = 1'b0, cfg_mux = 1'b0, cfg_wr_lowbyte = 1'b0, cfg_ready_en = 1'b0;
  logic ready = 1'b0;
  logic [15:0] bus_din = '0;
  logic ale, rd_n, wr_n, busy, done;
  logic [7:0] seg_addr;
  logic [15:0] bus_addr, bus_dout, rdata;

  int n_checks = 0;
  int n_fail = 0;
  logic [15:0] exp_rdata = '0;

  always #10 clk = ~clk;

  ext_bus_strobe_ctl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .cfg_bus16(cfg_bus16), .cfg_mux(cfg_mux), .cfg_wr_lowbyte(cfg_wr_lowbyte),
    .cfg_ready_en(cfg_ready_en), .ready(ready), .bus_din(bus_din),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .seg_addr(seg_addr), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .busy(busy), .done(done), .rdata(rdata)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int strobe_len(input logic ren, input logic rpre, input int drop);
    if (ren && rpre) return drop + 1;
    return 1;
  endfunction

  function automatic logic wr_expected(input logic wr, input logic lowmode, input logic b16, input logic [1:0] be);
    return wr && (!lowmode || !b16 || be[0]);
  endfunction

  task automatic run_access(input logic [23:0] addr, input logic wr, input logic [1:0] be,
                            input logic b16, input logic mux, input logic lowmode,
                            input logic ren, input logic rpre, input int drop, input logic hold);
    int s_len;
    logic wexp;
    logic [15:0] din_at_release;
    s_len = strobe_len(ren, rpre, drop);
    wexp = wr_expected(wr, lowmode, b16, be);
    din_at_release = '0;
    @(negedge clk);
    cfg_bus16 = b16; cfg_mux = mux; cfg_wr_lowbyte = lowmode; cfg_ready_en = ren;
    ready = rpre;
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_write = wr; req_be = be;
    req_wdata = 16'($urandom); bus_din = 16'($urandom);
    if (drop == 0) ready = 1'b0;
    for (int t = 1; t <= s_len + 3; t++) begin
      @(negedge clk);
      begin
        logic in_strobe;
        in_strobe = (t >= 2) && (t <= s_len + 1);
        check(ale == (mux && t == 1), "R2 ale", 32'(ale), 32'(mux && t == 1));
        check(rd_n == !(in_strobe && !wr), wr ? "R3 rd_n on write" : "R3 rd_n", 32'(rd_n), 32'(!(in_strobe && !wr)));
        if (!lowmode) check(wr_n == !(in_strobe && wexp), "R4 wr_n", 32'(wr_n), 32'(!(in_strobe && wexp)));
        else if (b16) check(wr_n == !(in_strobe && wexp), "R5 wr_n", 32'(wr_n), 32'(!(in_strobe && wexp)));
        else check(wr_n == !(in_strobe && wexp), "R6 wr_n", 32'(wr_n), 32'(!(in_strobe && wexp)));
        if (ren) check(rd_n == !(in_strobe && !wr) && wr_n == !(in_strobe && wexp), "R7 strobe length", {rd_n, wr_n}, 32'(t));
        else check((rd_n && wr_n) || t == 2, "R8 ready ignored", {rd_n, wr_n}, 32'(t));
        check(!(!rd_n && !wr_n) && !(ale && (!rd_n || !wr_n)), "R9 overlap", {ale, rd_n, wr_n}, 32'h3);
        if (t <= s_len + 2) begin
          check(seg_addr == addr[23:16], "R10 seg_addr", seg_addr, addr[23:16]);
          check(bus_addr == addr[15:0], "R10 bus_addr", bus_addr, addr[15:0]);
        end
        check(done == (t == s_len + 2), "R11 done", done, 32'(t == s_len + 2));
        if (t == s_len + 2) check(rdata == exp_rdata, "R11 rdata", rdata, exp_rdata);
        check(busy == (t <= s_len + 2), "R12 busy", busy, 32'(t <= s_len + 2));
      end
      req_valid = hold && (t == 1);
      if (t == drop) ready = 1'b0;
      bus_din = 16'($urandom);
      if (t == s_len + 1) begin
        din_at_release = bus_din;
        if (!wr) exp_rdata = din_at_release;
      end
    end
    req_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ale && rd_n && wr_n && !done && !busy && rdata == 0, "R1 reset state",
          {ale, rd_n, wr_n, done, busy}, 32'b01100);
    // directed corners
    run_access(24'hA51234, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 3, 1'b0); // R3 R8 read, ready ignored
    run_access(24'h7F0001, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0); // R4
    run_access(24'h01FFFE, 1'b1, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 0, 1'b0); // R5 high byte only
    run_access(24'h01FFFE, 1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 0, 1'b0); // R5 low byte
    run_access(24'hFF00AA, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0); // R6
    run_access(24'h123456, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 0, 1'b0); // R7 drop with request
    run_access(24'h654321, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 5, 1'b0); // R7 long wait
    run_access(24'h0F0F0F, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0); // R7 ready low
    run_access(24'hC0FFEE, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2, 1'b1); // R12 held request
    for (int n = 0; n < 300; n++) begin
      run_access(24'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 6)), 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule